// File: doc/BRIEF.md
# Interlocked Read Handshake Link

This block carries single read transfers from a requesting side to a responding side across a bus that has no shared timing: every control line is sampled by the receiving side through a two-flop synchronizer before it is acted on. Address and returned data travel on one set of shared lines. Each side drives those lines only in its own phase, through its own enable. The block resolves them into one observable bus value.

The requesting side accepts a command with an address on a local port and reports busy while the transfer runs. It presents the read word with a one-cycle done pulse. The responding side holds a small read-only word array whose contents are computed from the address. It waits a parameterised number of cycles after the address phase before it offers the data. A transfer is two fully interlocked request/acknowledge exchanges: one for the address and one for the data.

The bus lines are brought out as outputs so the phase ordering can be observed.

Top module: `hs_read_link`

## Requirements
- R1: After reset, bus_req, bus_slv_ack, bus_drdy, bus_mst_ack, busy and done are all 0, and bus_ad reads 0.
- R2: A cmd_valid pulse seen while not busy starts a transfer. bus_req rises, busy goes high, and bus_ad carries cmd_addr zero-extended for as long as bus_req is high.
- R3: bus_slv_ack rises only after the responder has seen bus_req high. The requester drops bus_req and releases the lines only after it has seen bus_slv_ack high, so bus_ad reads 0 once bus_req is low.
- R4: bus_slv_ack falls only after the responder has seen bus_req low.
- R5: bus_drdy rises exactly ACCESS_DLY+1 cycles after bus_slv_ack falls. While bus_drdy is high, bus_ad carries the word stored at the captured address.
- R6: bus_mst_ack rises only after the requester has seen bus_drdy high. bus_drdy falls and the data lines are released only after the responder has seen bus_mst_ack high. bus_mst_ack then falls.
- R7: After bus_mst_ack falls, done is high for exactly one cycle with done_data equal to the read word, and busy is low in that same cycle.
- R8: cmd_valid is ignored while busy. The running transfer returns the word for its own address, and no further transfer starts after it ends.
- R9: The two sides never drive the shared lines in the same cycle, and bus_ad reads 0 when neither side drives.
- R10: The word at address a is the low DATA_W bits of a*40503 + 4660.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | One-cycle read command strobe |
| cmd_addr | input | ADDR_W | Address of the read |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle completion pulse |
| done_data | output | DATA_W | Read word, valid with done |
| bus_req | output | 1 | Requester's read request line |
| bus_slv_ack | output | 1 | Responder's address acknowledge line |
| bus_drdy | output | 1 | Responder's data ready line |
| bus_mst_ack | output | 1 | Requester's data acknowledge line |
| bus_ad | output | max(ADDR_W,DATA_W) | Resolved shared address/data lines |

## Verification
Random addresses across the whole array check that the address phase and the data phase stay tied to the right word. Address 0 and the top address confirm that zero-extension and the computed contents are right at the edges of the range. Back-to-back commands, each issued in the cycle right after done, show that no handshake line is left asserted between transfers. A command injected during the data phase separates a requester that ignores it from one that would corrupt the captured address or start a stray transfer.

// File: rtl/hs_bus_pkg.sv
package hs_bus_pkg;

  typedef enum logic [1:0] {
    M_IDLE,
    M_REQ,
    M_WAIT_DR,
    M_ACK
  } mst_state_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ACK,
    S_WAIT,
    S_DRDY,
    S_REL
  } slv_state_t;

  // Contents of the responder array: a * 0x9E37 + 0x1234, caller truncates
  function automatic logic [31:0] fill_word(input logic [31:0] a);
    return a * 32'h0000_9E37 + 32'h0000_1234;
  endfunction

endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1, stage2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= d;
      stage2 <= stage1;
    end
  end

  assign q = stage2;
endmodule

// File: rtl/hs_master.sv
module hs_master
  import hs_bus_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int AD_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [ADDR_W-1:0] cmd_addr,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] done_data,
  output logic              req,
  output logic              mack,
  input  logic              sack_in,
  input  logic              drdy_in,
  input  logic [DATA_W-1:0] bus_in,
  output logic [AD_W-1:0]   ad_out,
  output logic              ad_en
);
  mst_state_t state, state_nx;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              done_q;
  logic              sack_s, drdy_s;

  hs_sync #(.W(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({sack_in, drdy_in}),
    .q     ({sack_s, drdy_s})
  );

  // named events
  logic accept_cmd, capture_data, finish;
  assign accept_cmd   = (state == M_IDLE) && cmd_valid;
  assign capture_data = (state == M_WAIT_DR) && drdy_s;
  assign finish       = (state == M_ACK) && !drdy_s;

  always_comb begin
    state_nx = state;
    unique case (state)
      M_IDLE:    if (cmd_valid) state_nx = M_REQ;
      M_REQ:     if (sack_s)    state_nx = M_WAIT_DR;
      M_WAIT_DR: if (drdy_s)    state_nx = M_ACK;
      M_ACK:     if (!drdy_s)   state_nx = M_IDLE;
      default:                  state_nx = M_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= M_IDLE;
      addr_q <= '0;
      data_q <= '0;
      done_q <= 1'b0;
    end else begin
      state  <= state_nx;
      done_q <= finish;
      if (accept_cmd)   addr_q <= cmd_addr;
      if (capture_data) data_q <= bus_in;
    end
  end

  assign req       = (state == M_REQ);
  assign ad_en     = (state == M_REQ);
  assign ad_out    = AD_W'(addr_q);
  assign mack      = (state == M_ACK);
  assign busy      = (state != M_IDLE);
  assign done      = done_q;
  assign done_data = data_q;

  // R3
  req_drop_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req) |-> $past(sack_s));

  // R6
  mack_after_drdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mack) |-> $past(drdy_s));

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  addr_hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_valid) |=> $stable(addr_q));
endmodule

// File: rtl/hs_slave.sv
module hs_slave
  import hs_bus_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 16,
  parameter int AD_W       = 16,
  parameter int ACCESS_DLY = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_in,
  input  logic              mack_in,
  input  logic [ADDR_W-1:0] bus_in,
  output logic              sack,
  output logic              drdy,
  output logic [AD_W-1:0]   ad_out,
  output logic              ad_en
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CNT_W = $clog2(ACCESS_DLY + 2);

  slv_state_t state, state_nx;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [CNT_W-1:0]  cnt;
  logic              req_s, mack_s;
  logic [DATA_W-1:0] rom [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_rom
    assign rom[g] = DATA_W'(fill_word(32'(g)));
  end

  hs_sync #(.W(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({req_in, mack_in}),
    .q     ({req_s, mack_s})
  );

  // named events
  logic take_addr, delay_done;
  assign take_addr  = (state == S_IDLE) && req_s;
  assign delay_done = (state == S_WAIT) && (cnt == CNT_W'(ACCESS_DLY));

  always_comb begin
    state_nx = state;
    unique case (state)
      S_IDLE: if (req_s)      state_nx = S_ACK;
      S_ACK:  if (!req_s)     state_nx = S_WAIT;
      S_WAIT: if (delay_done) state_nx = S_DRDY;
      S_DRDY: if (mack_s)     state_nx = S_REL;
      S_REL:  if (!mack_s)    state_nx = S_IDLE;
      default:                state_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      addr_q <= '0;
      data_q <= '0;
      cnt    <= '0;
    end else begin
      state <= state_nx;
      if (take_addr) addr_q <= bus_in;
      if (state == S_ACK)               cnt <= '0;
      else if (state == S_WAIT && !delay_done) cnt <= cnt + 1'b1;
      if (delay_done) data_q <= rom[addr_q];
    end
  end

  assign sack   = (state == S_ACK);
  assign drdy   = (state == S_DRDY);
  assign ad_en  = (state == S_DRDY);
  assign ad_out = AD_W'(data_q);

  // independent gap counter for the access-delay check
  logic        sack_q;
  logic [15:0] gap_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sack_q  <= 1'b0;
      gap_cnt <= '0;
    end else begin
      sack_q <= sack;
      if (sack_q && !sack)       gap_cnt <= 16'd1;
      else if (gap_cnt != 16'hFFFF) gap_cnt <= gap_cnt + 16'd1;
    end
  end

  // R3
  sack_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sack) |-> $past(req_s));

  // R4
  sack_drop_after_req_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sack) |-> $past(!req_s));

  // R5
  access_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drdy) |-> (gap_cnt == 16'(ACCESS_DLY + 1)));

  // R6
  drdy_drop_after_mack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drdy) |-> $past(mack_s));
endmodule

// File: rtl/hs_read_link.sv
module hs_read_link #(
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 16,
  parameter int ACCESS_DLY = 3
) (
  input  logic                                          clk,
  input  logic                                          rst_n,
  input  logic                                          cmd_valid,
  input  logic [ADDR_W-1:0]                             cmd_addr,
  output logic                                          busy,
  output logic                                          done,
  output logic [DATA_W-1:0]                             done_data,
  output logic                                          bus_req,
  output logic                                          bus_slv_ack,
  output logic                                          bus_drdy,
  output logic                                          bus_mst_ack,
  output logic [((ADDR_W > DATA_W) ? ADDR_W : DATA_W)-1:0] bus_ad
);
  localparam int AD_W = (ADDR_W > DATA_W) ? ADDR_W : DATA_W;

  logic [AD_W-1:0] m_ad, s_ad;
  logic            m_en, s_en;

  hs_master #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .AD_W(AD_W)) u_master (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_addr  (cmd_addr),
    .busy      (busy),
    .done      (done),
    .done_data (done_data),
    .req       (bus_req),
    .mack      (bus_mst_ack),
    .sack_in   (bus_slv_ack),
    .drdy_in   (bus_drdy),
    .bus_in    (bus_ad[DATA_W-1:0]),
    .ad_out    (m_ad),
    .ad_en     (m_en)
  );

  hs_slave #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .AD_W(AD_W),
             .ACCESS_DLY(ACCESS_DLY)) u_slave (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_in  (bus_req),
    .mack_in (bus_mst_ack),
    .bus_in  (bus_ad[ADDR_W-1:0]),
    .sack    (bus_slv_ack),
    .drdy    (bus_drdy),
    .ad_out  (s_ad),
    .ad_en   (s_en)
  );

  always_comb begin
    if (m_en)      bus_ad = m_ad;
    else if (s_en) bus_ad = s_ad;
    else           bus_ad = '0;
  end

  // R9
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(m_en && s_en));
endmodule

// File: tb/hs_read_link_test.sv
`timescale 1ns/1ps
module hs_read_link_test;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 16;
  localparam int DLY    = 3;
  localparam int LIMIT  = 60;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cmd_valid = 1'b0;
  logic [ADDR_W-1:0] cmd_addr = '0;
  logic              busy, done;
  logic [DATA_W-1:0] done_data;
  logic              bus_req, bus_slv_ack, bus_drdy, bus_mst_ack;
  logic [DATA_W-1:0] bus_ad;

  int total = 0;
  int fails = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  hs_read_link #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ACCESS_DLY(DLY)) uut (
    .clk, .rst_n, .cmd_valid, .cmd_addr, .busy, .done, .done_data,
    .bus_req, .bus_slv_ack, .bus_drdy, .bus_mst_ack, .bus_ad
  );

  // R10: restated through 32-bit integer arithmetic
  function automatic logic [DATA_W-1:0] exp_word(input int a);
    int v;
    v = a * 40503 + 4660;
    return v[DATA_W-1:0];
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  function automatic logic sig(input int sel);
    case (sel)
      0: return bus_req;
      1: return bus_slv_ack;
      2: return bus_drdy;
      3: return bus_mst_ack;
      default: return done;
    endcase
  endfunction

  // wait (sampling at negedges) until line sel equals val
  task automatic wait_sig(input int sel, input logic val, input string rq);
    int n;
    n = 0;
    while (sig(sel) !== val && n < LIMIT) begin
      @(negedge clk);
      n++;
    end
    if (sig(sel) !== val) chk(1'b0, rq, "handshake timeout", sel, val);
  endtask

  task automatic do_read(input int a, input bit inject);
    logic [DATA_W-1:0] e;
    int gap;
    e = exp_word(a);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_addr  = ADDR_W'(a);
    @(negedge clk);
    cmd_valid = 1'b0;
    // R2
    wait_sig(0, 1'b1, "R2");
    chk(bus_ad == DATA_W'(a), "R2", "address on bus", bus_ad, a);
    chk(busy == 1'b1, "R2", "busy during transfer", busy, 1);
    // R3
    wait_sig(1, 1'b1, "R3");
    chk(bus_req == 1'b1, "R3", "req still high at slave ack", bus_req, 1);
    wait_sig(0, 1'b0, "R3");
    chk(bus_slv_ack == 1'b1 && bus_ad == '0, "R3", "ack held, lines released",
        bus_ad, 0);
    // R4
    wait_sig(1, 1'b0, "R4");
    chk(bus_req == 1'b0 && bus_drdy == 1'b0, "R4", "ack falls after req low",
        bus_req, 0);
    // R5
    gap = 0;
    while (bus_drdy == 1'b0 && gap < LIMIT) begin
      gap++;
      @(negedge clk);
    end
    chk(gap == DLY + 1, "R5", "access gap cycles", gap, DLY + 1);
    chk(bus_ad == e, "R5", "data on bus with drdy", bus_ad, e);
    if (inject) begin
      cmd_valid = 1'b1;
      cmd_addr  = ~ADDR_W'(a);
      @(negedge clk);
      cmd_valid = 1'b0;
    end
    // R6
    wait_sig(3, 1'b1, "R6");
    chk(bus_drdy == 1'b1, "R6", "drdy held at master ack", bus_drdy, 1);
    wait_sig(2, 1'b0, "R6");
    chk(bus_mst_ack == 1'b1 && bus_ad == '0, "R6", "data released, ack held",
        bus_ad, 0);
    wait_sig(3, 1'b0, "R6");
    // R7
    wait_sig(4, 1'b1, "R7");
    chk(done_data == e, "R7", "done data", done_data, e);
    chk(busy == 1'b0, "R7", "busy low with done", busy, 0);
    @(negedge clk);
    chk(done == 1'b0, "R7", "done one cycle", done, 0);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        chk(1'b0, "WD", "watchdog expired", cycles, 0);
        summary();
      end
    end
  end

  initial begin
    int quiet;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1
    chk({bus_req, bus_slv_ack, bus_drdy, bus_mst_ack, busy, done} == 6'b0,
        "R1", "control lines in reset", 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({bus_req, bus_slv_ack, bus_drdy, bus_mst_ack, busy, done} == 6'b0,
        "R1", "control lines after reset", 0, 0);
    chk(bus_ad == '0, "R1", "bus idle value (R9)", bus_ad, 0);

    // R10 corners
    do_read(0, 1'b0);
    do_read((1 << ADDR_W) - 1, 1'b0);

    // R8: command during the data phase is ignored
    do_read(21, 1'b1);
    quiet = 0;
    repeat (8) begin
      @(negedge clk);
      if (bus_req || busy) quiet++;
    end
    chk(quiet == 0, "R8", "no stray transfer", quiet, 0);

    // random back-to-back reads
    for (int i = 0; i < 24; i++) begin
      do_read(int'($urandom % (1 << ADDR_W)), (i % 5) == 4);
    end

    // R9: bus returns to zero when idle
    repeat (4) @(negedge clk);
    chk(bus_ad == '0, "R9", "bus idle value", bus_ad, 0);
    summary();
  end
endmodule